// File: doc/BRIEF.md
# Supply Undervoltage Fault Status Controller

This block gathers three supply-undervoltage comparator outputs: the core supply, the 1.8V supply and the I/O supply. It turns them into sticky status bits, two interrupt flags and an active-low error pin. Each comparator output is asynchronous and is resynchronised before it is used. A core-supply undervoltage also drives a core reset request, which stays asserted until the supply has recovered.

The status bits and both flags sit in an always-on domain that only the power-on reset clears. So after the core recovers, software can still see that a brownout happened. The two error-pin enable bits live in the core domain, and the core reset request clears them.

Software clears the flags by reading. First it reads the status register, which clears the status bits. Then it reads the flag register, which clears the flag.

Top module: `supply_uv_monitor`

## Requirements
- R1: After power-on reset, with no undervoltage, the register reads are as follows. Address 0 reads 0. Address 1 reads 7. Address 2 reads 0. Address 3 reads 0. `err_n_o` is 1 and `core_rst_n_o` is 1.
- R2: A core undervoltage sets the brownout status to 3 in bits [1:0] of address 0. It also clears comparator status bit 2 at address 1.
- R3: `core_rst_n_o` goes low two clock edges after a core undervoltage input rises, and stays low until the synchronised input falls. While it is low, the enable register is cleared. The status bits and flags are not cleared.
- R4: A 1.8V undervoltage latches bit 0 of address 1 low. An I/O undervoltage latches bit 1 of address 1 low.
- R5: A read of address 0 clears the brownout status, and a read of address 1 sets every comparator status bit back to 1. A bit whose fault is still present is not cleared.
- R6: A read of address 2 affects each flag separately. It clears flag bit 0 (brownout) only if the brownout status is already 0. It clears flag bit 1 (comparator) only if the comparator status is already 7. Otherwise the flag stays set.
- R7: A flag sets when one of its own status bits newly enters the fault state. Address 2 bit 0 is the brownout flag, and bit 1 is the comparator flag.
- R8: `wr_en` writes `wr_data` into the enable register, which reads back at address 3. Bit 0 enables the brownout flag and bit 1 enables the comparator flag. `err_n_o` is low exactly when an enabled flag is set.
- R9: Each comparator input passes through a two-flop synchronizer. An input that rises before clock edge k shows up in the status register after edge k+2, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aon_rst_n | input | 1 | Power-on reset of the always-on domain, synchronous, active low |
| uv_core_i | input | 1 | Core supply undervoltage comparator, asynchronous |
| uv_18_i | input | 1 | 1.8V supply undervoltage comparator, asynchronous |
| uv_io_i | input | 1 | I/O supply undervoltage comparator, asynchronous |
| rd_en | input | 1 | Read strobe; a read has side effects at the clock edge |
| rd_addr | input | 2 | Register address |
| rd_data | output | 8 | Read data of the addressed register, before the read's side effect |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 2 | Enable bits to write |
| core_rst_n_o | output | 1 | Core reset request, active low |
| err_n_o | output | 1 | Error pin, active low |

## Verification
The bench sweeps all eight combinations of the three faults against all four enable settings. In every case it walks the clearing sequence in both the wrong order and the right order.

A design that cleared a flag on a premature flag read would lose the event before software reads the status. A design that let a status read win over a fault that is still present would report a clean supply during the fault. The bench also checks that the status is still clean two edges after a fault rises. A design with one synchronizer stage too few or too many would fail that check.

Finally, it checks that a core brownout clears the enables but keeps its own status and flag. A design that reset the always-on storage from the core reset would lose the brownout record.

// File: rtl/uv_pkg.sv
// Shared constants for the supply undervoltage controller.
// Assumes a 2-bit register address space and three supplies.
package uv_pkg;
    localparam int NUM_SUP = 3;
    localparam int SUP_18   = 0;
    localparam int SUP_IO   = 1;
    localparam int SUP_CORE = 2;
    localparam int ADDR_W  = 2;
    localparam logic [ADDR_W-1:0] A_BO   = 2'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;
    localparam logic [ADDR_W-1:0] A_EN   = 2'd3;
    localparam int FLAG_BO  = 0;
    localparam int FLAG_CMP = 1;
endpackage

// File: rtl/uv_sync.sv
// Multi-stage synchronizer for one asynchronous comparator bit.
// Assumes STAGES >= 2; reset value is "no fault".
module uv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/uv_aon_status.sv
// Always-on status and flag storage. Only the power-on reset clears it.
// Brownout status latches high; comparator status bits latch low.
// Assumes uv_s is already synchronous and read strobes are one cycle long.
module uv_aon_status
    import uv_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUP-1:0] uv_s,
    input  logic               rd_bo,
    input  logic               rd_cmp,
    input  logic               rd_flag,
    output logic [1:0]         bo_status,
    output logic [NUM_SUP-1:0] cmp_status,
    output logic [1:0]         flags
);
    logic bo_new;
    logic cmp_new;

    assign bo_new  = uv_s[SUP_CORE] && (bo_status == 2'b00);
    assign cmp_new = |(uv_s & cmp_status);

    // Brownout status: a fault wins over a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)              bo_status <= 2'b00;
        else if (uv_s[SUP_CORE]) bo_status <= 2'b11;
        else if (rd_bo)          bo_status <= 2'b00;
    end

    // One comparator status bit per supply, active low.
    for (genvar i = 0; i < NUM_SUP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)       cmp_status[i] <= 1'b1;
            else if (uv_s[i]) cmp_status[i] <= 1'b0;
            else if (rd_cmp)  cmp_status[i] <= 1'b1;
        end
    end

    // Brownout flag: set on a new fault, cleared only after its status is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flags[FLAG_BO] <= 1'b0;
        else if (bo_new)                           flags[FLAG_BO] <= 1'b1;
        else if (rd_flag && bo_status == 2'b00)    flags[FLAG_BO] <= 1'b0;
    end

    // Comparator flag: same rule against the comparator status.
    always_ff @(posedge clk) begin
        if (!rst_n)                                flags[FLAG_CMP] <= 1'b0;
        else if (cmp_new)                          flags[FLAG_CMP] <= 1'b1;
        else if (rd_flag && (&cmp_status))         flags[FLAG_CMP] <= 1'b0;
    end
endmodule

// File: rtl/uv_core_regs.sv
// Core-domain enable register, read multiplexer and error pin.
// Assumes core_hold is the synchronised core undervoltage; it clears the enables.
module uv_core_regs
    import uv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_hold,
    input  logic               wr_en,
    input  logic [1:0]         wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic [1:0]         bo_status,
    input  logic [NUM_SUP-1:0] cmp_status,
    input  logic [1:0]         flags,
    output logic [DATA_W-1:0]  rd_data,
    output logic [1:0]         en,
    output logic               err_n
);
    // Enable bits: cleared by power-on or core reset, loaded by a write.
    always_ff @(posedge clk) begin
        if (!rst_n || core_hold) en <= 2'b00;
        else if (wr_en)          en <= wr_data;
    end

    // Select the addressed register, zero-extended.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_BO:    rd_data[1:0]         = bo_status;
            A_CMP:   rd_data[NUM_SUP-1:0] = cmp_status;
            A_FLAG:  rd_data[1:0]         = flags;
            default: rd_data[1:0]         = en;
        endcase
    end

    assign err_n = ~|(flags & en);
endmodule

// File: rtl/supply_uv_monitor.sv
// Top of the supply undervoltage controller: synchronizes the comparators,
// decodes reads and combines the always-on and core-domain parts.
// Assumes rd_en is a single-cycle strobe.
module supply_uv_monitor
    import uv_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              aon_rst_n,
    input  logic              uv_core_i,
    input  logic              uv_18_i,
    input  logic              uv_io_i,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_data,
    output logic              core_rst_n_o,
    output logic              err_n_o
);
    logic [NUM_SUP-1:0] uv_raw;
    logic [NUM_SUP-1:0] uv_s;
    logic [1:0]         bo_status;
    logic [NUM_SUP-1:0] cmp_status;
    logic [1:0]         flags;
    logic [1:0]         en;

    assign uv_raw[SUP_18]   = uv_18_i;
    assign uv_raw[SUP_IO]   = uv_io_i;
    assign uv_raw[SUP_CORE] = uv_core_i;

    for (genvar i = 0; i < NUM_SUP; i++) begin : g_sync
        uv_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(aon_rst_n),
            .d_i  (uv_raw[i]),
            .q_o  (uv_s[i])
        );
    end

    uv_aon_status u_aon (
        .clk       (clk),
        .rst_n     (aon_rst_n),
        .uv_s      (uv_s),
        .rd_bo     (rd_en && rd_addr == A_BO),
        .rd_cmp    (rd_en && rd_addr == A_CMP),
        .rd_flag   (rd_en && rd_addr == A_FLAG),
        .bo_status (bo_status),
        .cmp_status(cmp_status),
        .flags     (flags)
    );

    uv_core_regs #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (aon_rst_n),
        .core_hold (uv_s[SUP_CORE]),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .bo_status (bo_status),
        .cmp_status(cmp_status),
        .flags     (flags),
        .rd_data   (rd_data),
        .en        (en),
        .err_n     (err_n_o)
    );

    assign core_rst_n_o = aon_rst_n & ~uv_s[SUP_CORE];
endmodule

// File: rtl/supply_uv_monitor_chk.sv
// Assertion checker for supply_uv_monitor, attached with bind.
module supply_uv_monitor_chk (
    input logic       clk,
    input logic       aon_rst_n,
    input logic       core_rst_n_o,
    input logic       err_n_o,
    input logic       rd_en,
    input logic [1:0] rd_addr,
    input logic [1:0] bo_status,
    input logic [2:0] cmp_status,
    input logic [2:0] uv_s,
    input logic [1:0] flags,
    input logic [1:0] en
);
    // R2: the cycle after the core reset request, the brownout status is latched
    assert_bo_latch_R2: assert property (@(posedge clk) disable iff (!aon_rst_n)
        !core_rst_n_o |=> bo_status == 2'b11);

    // R3: the core reset request clears the enables
    assert_core_clears_en_R3: assert property (@(posedge clk) disable iff (!aon_rst_n)
        !core_rst_n_o |=> en == 2'b00);

    // R4: a synchronised 1.8V fault latches its bit low
    assert_cmp18_low_R4: assert property (@(posedge clk) disable iff (!aon_rst_n)
        uv_s[0] |=> !cmp_status[0]);

    // R6: a flag read before the status is cleared keeps the brownout flag
    assert_flag_kept_R6: assert property (@(posedge clk) disable iff (!aon_rst_n)
        (rd_en && rd_addr == 2'd2 && bo_status != 2'b00 && flags[0]) |=> flags[0]);

    // R7: the brownout flag only rises together with a latched status
    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (!aon_rst_n)
        $rose(flags[0]) |-> bo_status == 2'b11);

    // R8: with no enable set the error pin stays released
    assert_err_idle_R8: assert property (@(posedge clk) disable iff (!aon_rst_n)
        en == 2'b00 |-> err_n_o);
endmodule

bind supply_uv_monitor supply_uv_monitor_chk u_chk (
    .clk         (clk),
    .aon_rst_n   (aon_rst_n),
    .core_rst_n_o(core_rst_n_o),
    .err_n_o     (err_n_o),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .bo_status   (bo_status),
    .cmp_status  (cmp_status),
    .uv_s        (uv_s),
    .flags       (flags),
    .en          (en)
);

// File: tb/supply_uv_monitor_test.sv
`timescale 1ns/1ps
// Sweeps every fault combination against every enable setting.
module supply_uv_monitor_test;
    logic       clk = 1'b0;
    logic       aon_rst_n = 1'b0;
    logic       uv_core_i = 1'b0, uv_18_i = 1'b0, uv_io_i = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] rd_addr = 2'd0, wr_data = 2'd0;
    logic [7:0] rd_data;
    logic       core_rst_n_o, err_n_o;
    int         n_tests = 0, n_fail = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    supply_uv_monitor uut (
        .clk(clk), .aon_rst_n(aon_rst_n),
        .uv_core_i(uv_core_i), .uv_18_i(uv_18_i), .uv_io_i(uv_io_i),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_data(wr_data),
        .core_rst_n_o(core_rst_n_o), .err_n_o(err_n_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Look at a register without a read strobe, so without side effects.
    task automatic peek(input logic [1:0] a, input string req, input int exp);
        rd_addr = a;
        #1;
        check(req, int'(rd_data), exp);
    endtask

    task automatic do_read(input logic [1:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        aon_rst_n = 1'b1;
        @(negedge clk);
        peek(2'd0, "R1 bo", 0);
        peek(2'd1, "R1 cmp", 7);
        peek(2'd2, "R1 flags", 0);
        peek(2'd3, "R1 en", 0);
        check("R1 err_n", err_n_o, 1);
        check("R1 core_rst_n", core_rst_n_o, 1);

        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 4; e++) begin
                int core, cmp_exp, fl_exp, en_exp;
                core    = (p >> 2) & 1;
                cmp_exp = 7 & ~p;
                fl_exp  = core | ((p != 0) ? 2 : 0);
                en_exp  = core ? 0 : e;

                do_write(2'(e));
                peek(2'd3, "R8 en readback", e);

                // Raise faults; two edges later nothing has latched yet.
                uv_18_i = p[0]; uv_io_i = p[1]; uv_core_i = p[2];
                repeat (2) @(negedge clk);
                peek(2'd0, "R9 bo not yet", 0);
                peek(2'd1, "R9 cmp not yet", 7);
                check("R3 core_rst_n during fault", core_rst_n_o, core ? 0 : 1);
                @(negedge clk);
                peek(2'd0, "R2 bo latched", core ? 3 : 0);
                peek(2'd1, "R4 cmp latched", cmp_exp);
                peek(2'd2, "R7 flags set", fl_exp);

                // Clearing reads while the faults remain have no effect.
                do_read(2'd0);
                peek(2'd0, "R5 bo held", core ? 3 : 0);
                do_read(2'd1);
                peek(2'd1, "R5 cmp held", cmp_exp);
                do_read(2'd2);
                peek(2'd2, "R6 flags held", fl_exp);

                uv_18_i = 1'b0; uv_io_i = 1'b0; uv_core_i = 1'b0;
                repeat (3) @(negedge clk);
                check("R3 core_rst_n released", core_rst_n_o, 1);
                peek(2'd3, "R3 en after core reset", en_exp);
                peek(2'd0, "R3 bo survives", core ? 3 : 0);
                check("R8 err_n", err_n_o, ((fl_exp & en_exp) != 0) ? 0 : 1);

                // Wrong order: flag read first keeps both flags.
                do_read(2'd2);
                peek(2'd2, "R6 early flag read", fl_exp);
                // Right order for the brownout, not yet for the comparator.
                do_read(2'd0);
                peek(2'd0, "R5 bo cleared", 0);
                do_read(2'd2);
                peek(2'd2, "R6 bo flag cleared", fl_exp & 2);
                do_read(2'd1);
                peek(2'd1, "R5 cmp cleared", 7);
                do_read(2'd2);
                peek(2'd2, "R6 cmp flag cleared", 0);
                check("R8 err_n idle", err_n_o, 1);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule